// File: doc/BRIEF.md
# Audio Serial Clock Ratio Monitor

This block watches the bit clock and the frame sync of an audio serial port from a free-running reference clock. It counts bit-clock rising edges between successive frame-sync rising edges and checks that count against the set of ratios legal for the programmed sample rate. Sample rates are grouped into a 48 kHz family and a 44.1 kHz family. Each rate has its own subset of allowed ratios.

A detected clock fault raises an error flag and, with it, a request for the playback path to fade its volume out. If the fault persists and halting is not disabled, a programmable timer runs, and on expiry a halt flag tells the path to enter a low-power state. An optional automatic mode drives a power-up request that follows the presence of valid clocking. Audio data and the volume ramp itself are handled elsewhere.

Top module: `aud_clk_ratio_mon`

## Requirements
- R1: Legal ratios are 16, 24, 32, 48, 64, 96, 125, 128, 192, 250, 256, 384, 500 and 512 bit clocks per frame, and any other count is invalid. The counts 125, 250 and 500 are valid only when `rate_fam_i`=0 (48 kHz family) and never when `rate_fam_i`=1 (44.1 kHz family).
- R2: Rate codes on `rate_sel_i` are 0..5. With `rate_fam_i`=0 they mean 16, 24, 32, 48, 96 and 192 kHz; with `rate_fam_i`=1 they mean 14.7, 22.05, 29.4, 44.1, 88.2 and 176.4 kHz. The low-ratio limits are: code 0 of family 0 rejects 16 and 24; code 1 of family 0 rejects 16; code 0 of family 1 rejects 16, 24 and 32; code 1 of family 1 rejects 16 and 24; code 2 of family 1 rejects 16.
- R3: The high-ratio limits are: code 4 of family 0 (96 kHz) rejects anything above 256; code 5 of family 0 (192 kHz) rejects anything above 128; code 4 of family 1 (88.2 kHz) rejects 512; code 5 of family 1 (176.4 kHz) rejects anything above 128 except 192.
- R4: `clk_err_o` rises only after two consecutive invalid frames and falls only after two consecutive valid frames. A single odd frame does not change it.
- R5: `ramp_dn_o` is high exactly while `clk_err_o` is high, and it drops once valid clocking returns.
- R6: While `clk_err_o`=1 and `halt_dis_i`=0, `halt_o` rises exactly HALT_BASE·2^`halt_sel_i` reference cycles after `clk_err_o` rose (HALT_BASE=64 by default).
- R7: While `halt_dis_i`=1, the halt timer is held at zero and `halt_o` stays 0.
- R8: When `clk_err_o` falls, `halt_o` clears and the halt timer restarts from zero.
- R9: If no frame-sync rising edge arrives within WD_LIMIT reference cycles, `clk_err_o` asserts without waiting for frames.
- R10: With `auto_pwr_i`=1 and `halt_dis_i`=0, `pwr_up_o` is 1 only while valid clocking is locked (two valid frames and no error). Otherwise `pwr_up_o` equals the inverse of `halt_o`.
- R11: A change of `rate_sel_i` or `rate_fam_i` while `auto_pwr_i`=1 forces `clk_err_o` high at once. The same change while `auto_pwr_i`=0 has no effect on the flag.
- R12: After reset `clk_err_o`, `ramp_dn_o` and `halt_o` are 0, and with `auto_pwr_i`=0 `pwr_up_o` is 1.
- R13: Rate codes 6 and 7 make every frame invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Serial bit clock, asynchronous |
| fsync_i | input | 1 | Frame sync, asynchronous |
| rate_sel_i | input | 3 | Sample-rate code within the family |
| rate_fam_i | input | 1 | 0 = 48 kHz family, 1 = 44.1 kHz family |
| halt_sel_i | input | 3 | Halt timer exponent |
| halt_dis_i | input | 1 | Disables the halt timer and automatic power mode |
| auto_pwr_i | input | 1 | Enables automatic power-up and power-down |
| clk_err_o | output | 1 | Clock fault flag |
| ramp_dn_o | output | 1 | Volume fade-out request |
| halt_o | output | 1 | Low-power halt request |
| pwr_up_o | output | 1 | Power-up request |

## Verification
Two functions can act in the same reference cycle: the end of the halt count and a return to valid clocking, or a forced error from a rate change that lands on the cycle in which a frame verdict would clear the flag. The bench provokes the first by letting an invalid stream run past the halt limit and then switching to legal frames. It judges the outcome by the exact distance between the error and halt edges, and by both flags clearing together. Random rate and mode switches under automatic power mode overlap forced errors with frame verdicts, and each run is judged only on the final settled flag pattern, which is predicted from the last frames.

// File: rtl/aud_crm_pkg.sv
package aud_crm_pkg;

   typedef enum logic [1:0] {
      LK_IDLE = 2'd0,
      LK_OK   = 2'd1,
      LK_ERR  = 2'd2
   } lock_e;

   // Legality of a measured bit-clock count for one rate code of one family.
   function automatic logic ratio_ok(input logic [9:0] n,
                                     input logic       fam44,
                                     input logic [2:0] code);
      logic odd_set;
      logic pow_set;
      logic ok;
      odd_set = (n == 10'd125) || (n == 10'd250) || (n == 10'd500);
      pow_set = (n == 10'd16)  || (n == 10'd24)  || (n == 10'd32)  ||
                (n == 10'd48)  || (n == 10'd64)  || (n == 10'd96)  ||
                (n == 10'd128) || (n == 10'd192) || (n == 10'd256) ||
                (n == 10'd384) || (n == 10'd512);
      ok = pow_set || (odd_set && !fam44);
      if (!fam44) begin
         case (code)
            3'd0:    if (n < 10'd32)  ok = 1'b0;
            3'd1:    if (n < 10'd24)  ok = 1'b0;
            3'd2,
            3'd3:    ;
            3'd4:    if (n > 10'd256) ok = 1'b0;
            3'd5:    if (n > 10'd128) ok = 1'b0;
            default: ok = 1'b0;
         endcase
      end else begin
         case (code)
            3'd0:    if (n < 10'd48)  ok = 1'b0;
            3'd1:    if (n < 10'd32)  ok = 1'b0;
            3'd2:    if (n < 10'd24)  ok = 1'b0;
            3'd3:    ;
            3'd4:    if (n > 10'd384) ok = 1'b0;
            3'd5:    if ((n > 10'd128) && (n != 10'd192)) ok = 1'b0;
            default: ok = 1'b0;
         endcase
      end
      return ok;
   endfunction

endpackage

// File: rtl/aud_crm_edge.sv
module aud_crm_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic rise_o
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;

   genvar gi;
   generate
      for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
         if (gi == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) sync_q[0] <= 1'b0;
               else         sync_q[0] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) sync_q[gi] <= 1'b0;
               else         sync_q[gi] <= sync_q[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) last_q <= 1'b0;
      else         last_q <= sync_q[SYNC_STAGES-1];
   end

   assign rise_o = sync_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/aud_crm_meter.sv
module aud_crm_meter
   import aud_crm_pkg::*;
#(
   parameter int CNT_W    = 11,
   parameter int WD_LIMIT = 4096,
   parameter int HYST     = 2
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       bclk_rise_i,
   input  logic       fs_rise_i,
   input  logic [2:0] rate_sel_i,
   input  logic       rate_fam_i,
   input  logic       auto_pwr_i,
   output logic       err_o,
   output logic       ok_o
);
   localparam int WD_W = $clog2(WD_LIMIT) + 1;
   localparam int RW   = $clog2(HYST) + 1;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic [WD_W-1:0]  wd_q;
   logic             primed_q;
   logic [3:0]       cfg_q;
   lock_e            st_q;
   logic [RW-1:0]    good_q, bad_q;

   logic [3:0] cfg_now;
   logic       wd_hit, cfg_jump, frame_done, frame_good, fits;

   assign cfg_now    = {rate_fam_i, rate_sel_i};
   assign wd_hit     = (wd_q == WD_W'(WD_LIMIT - 1));
   assign cfg_jump   = auto_pwr_i && (cfg_now != cfg_q);
   assign frame_done = fs_rise_i && primed_q;
   assign fits       = (cnt_q < CNT_W'(1024));
   assign frame_good = fits && ratio_ok(cnt_q[9:0], rate_fam_i, rate_sel_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q    <= '0;
         wd_q     <= '0;
         primed_q <= 1'b0;
         cfg_q    <= '0;
      end else begin
         cfg_q <= cfg_now;
         if (fs_rise_i)                         cnt_q <= CNT_W'(bclk_rise_i);
         else if (bclk_rise_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
         if (fs_rise_i)   wd_q <= '0;
         else if (!wd_hit) wd_q <= wd_q + 1'b1;
         if (fs_rise_i)   primed_q <= 1'b1;
         else if (wd_hit) primed_q <= 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= LK_IDLE;
         good_q <= '0;
         bad_q  <= '0;
      end else if (wd_hit || cfg_jump) begin
         st_q   <= LK_ERR;
         good_q <= '0;
         bad_q  <= '0;
      end else if (frame_done) begin
         if (frame_good) begin
            bad_q <= '0;
            if (good_q == RW'(HYST - 1)) st_q   <= LK_OK;
            else                         good_q <= good_q + 1'b1;
         end else begin
            good_q <= '0;
            if (bad_q == RW'(HYST - 1)) st_q  <= LK_ERR;
            else                        bad_q <= bad_q + 1'b1;
         end
      end
   end

   assign err_o = (st_q == LK_ERR);
   assign ok_o  = (st_q == LK_OK);
endmodule

// File: rtl/aud_crm_escal.sv
module aud_crm_escal #(
   parameter int HALT_BASE   = 64,
   parameter int HSEL_W      = 3,
   parameter bit AUTO_PWR_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              err_i,
   input  logic              ok_i,
   input  logic [HSEL_W-1:0] halt_sel_i,
   input  logic              halt_dis_i,
   input  logic              auto_pwr_i,
   output logic              ramp_dn_o,
   output logic              halt_o,
   output logic              pwr_up_o
);
   localparam int HMAX = HALT_BASE << ((1 << HSEL_W) - 1);
   localparam int HW   = $clog2(HMAX + 1);

   logic [HW-1:0] hcnt_q, hlim;
   logic          halt_q;

   assign hlim = HW'(HALT_BASE) << halt_sel_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hcnt_q <= '0;
         halt_q <= 1'b0;
      end else if (!err_i || halt_dis_i) begin
         hcnt_q <= '0;
         halt_q <= 1'b0;
      end else if (!halt_q) begin
         if (hcnt_q == hlim - 1'b1) halt_q <= 1'b1;
         else                       hcnt_q <= hcnt_q + 1'b1;
      end
   end

   assign ramp_dn_o = err_i;
   assign halt_o    = halt_q;

   generate
      if (AUTO_PWR_EN) begin : g_auto
         assign pwr_up_o = (auto_pwr_i && !halt_dis_i) ? ok_i : !halt_q;
      end else begin : g_fixed
         assign pwr_up_o = !halt_q;
      end
   endgenerate
endmodule

// File: rtl/aud_clk_ratio_mon.sv
module aud_clk_ratio_mon #(
   parameter int SYNC_STAGES = 2,
   parameter int MAX_RATIO   = 512,
   parameter int WD_LIMIT    = 4096,
   parameter int HALT_BASE   = 64,
   parameter int HYST        = 2,
   parameter bit AUTO_PWR_EN = 1'b1
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       bclk_i,
   input  logic       fsync_i,
   input  logic [2:0] rate_sel_i,
   input  logic       rate_fam_i,
   input  logic [2:0] halt_sel_i,
   input  logic       halt_dis_i,
   input  logic       auto_pwr_i,
   output logic       clk_err_o,
   output logic       ramp_dn_o,
   output logic       halt_o,
   output logic       pwr_up_o
);
   localparam int CNT_W = $clog2(MAX_RATIO) + 2;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (MAX_RATIO < 512) begin : g_bad_ratio
         $error("MAX_RATIO must cover 512");
      end
      if (HYST < 1) begin : g_bad_hyst
         $error("HYST must be at least 1");
      end
      if (WD_LIMIT < 4 * MAX_RATIO) begin : g_bad_wd
         $error("WD_LIMIT too short for the longest frame");
      end
      if (HALT_BASE < 1) begin : g_bad_halt
         $error("HALT_BASE must be positive");
      end
   endgenerate

   logic bclk_rise, fs_rise, err, ok;

   aud_crm_edge #(.SYNC_STAGES(SYNC_STAGES)) u_bclk_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(bclk_i),
      .rise_o (bclk_rise)
   );

   aud_crm_edge #(.SYNC_STAGES(SYNC_STAGES)) u_fs_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(fsync_i),
      .rise_o (fs_rise)
   );

   aud_crm_meter #(
      .CNT_W   (CNT_W),
      .WD_LIMIT(WD_LIMIT),
      .HYST    (HYST)
   ) u_meter (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .bclk_rise_i(bclk_rise),
      .fs_rise_i  (fs_rise),
      .rate_sel_i (rate_sel_i),
      .rate_fam_i (rate_fam_i),
      .auto_pwr_i (auto_pwr_i),
      .err_o      (err),
      .ok_o       (ok)
   );

   aud_crm_escal #(
      .HALT_BASE  (HALT_BASE),
      .HSEL_W     (3),
      .AUTO_PWR_EN(AUTO_PWR_EN)
   ) u_escal (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .err_i     (err),
      .ok_i      (ok),
      .halt_sel_i(halt_sel_i),
      .halt_dis_i(halt_dis_i),
      .auto_pwr_i(auto_pwr_i),
      .ramp_dn_o (ramp_dn_o),
      .halt_o    (halt_o),
      .pwr_up_o  (pwr_up_o)
   );

   assign clk_err_o = err;
endmodule

// File: rtl/aud_crm_chk.sv
module aud_crm_chk #(
   parameter bit AUTO_PWR_EN = 1'b1
) (
   input logic clk_i,
   input logic rst_ni,
   input logic halt_dis_i,
   input logic auto_pwr_i,
   input logic clk_err_o,
   input logic halt_o,
   input logic pwr_up_o
);
   AST_HALT_AFTER_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(halt_o) |-> $past(clk_err_o)); // R6

   AST_DIS_BLOCKS_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      halt_dis_i |=> !halt_o); // R7

   AST_HALT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clk_err_o |=> !halt_o); // R8

   generate
      if (AUTO_PWR_EN) begin : g_auto_chk
         AST_AUTO_PWR_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (auto_pwr_i && !halt_dis_i && clk_err_o) |-> !pwr_up_o); // R10
      end
   endgenerate
endmodule

bind aud_clk_ratio_mon aud_crm_chk #(.AUTO_PWR_EN(AUTO_PWR_EN)) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .halt_dis_i(halt_dis_i),
   .auto_pwr_i(auto_pwr_i),
   .clk_err_o (clk_err_o),
   .halt_o    (halt_o),
   .pwr_up_o  (pwr_up_o)
);

// File: tb/aud_clk_ratio_mon_tb.sv
module aud_clk_ratio_mon_tb;
   localparam int WD_LIMIT  = 4096;
   localparam int HALT_BASE = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bclk = 1'b1, fsync = 1'b0;
   logic [2:0] rate_sel = 3'd3, halt_sel = 3'd0;
   logic       rate_fam = 1'b0, halt_dis = 1'b0, auto_pwr = 1'b0;
   logic       clk_err, ramp_dn, halt, pwr_up;

   int  n_chk = 0, n_fail = 0;
   int  hlen = -1, hrun = 0;
   bit  done = 1'b0, err_seen = 1'b0, prev_halt = 1'b0;

   always #10 clk = ~clk;

   aud_clk_ratio_mon #(.WD_LIMIT(WD_LIMIT), .HALT_BASE(HALT_BASE)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .bclk_i(bclk), .fsync_i(fsync),
      .rate_sel_i(rate_sel), .rate_fam_i(rate_fam), .halt_sel_i(halt_sel),
      .halt_dis_i(halt_dis), .auto_pwr_i(auto_pwr),
      .clk_err_o(clk_err), .ramp_dn_o(ramp_dn), .halt_o(halt), .pwr_up_o(pwr_up)
   );

   // cycle distance from error rise to halt rise, sticky error observer
   always @(negedge clk) begin
      if (!clk_err || halt_dis) hrun <= 0;
      else if (!halt)           hrun <= hrun + 1;
      if (halt && !prev_halt)   hlen <= hrun;
      prev_halt <= halt;
      if (clk_err) err_seen <= 1'b1;
   end

   function automatic bit exp_ok(int r, bit f, int c);
      int lo0[6] = '{32, 24, 16, 16, 16, 16};
      int lo1[6] = '{48, 32, 24, 16, 16, 16};
      int hi0[6] = '{512, 512, 512, 512, 256, 128};
      int hi1[6] = '{512, 512, 512, 512, 384, 128};
      bit odd = (r == 125) || (r == 250) || (r == 500);
      bit listed = odd || (r inside {16, 24, 32, 48, 64, 96, 128, 192, 256, 384, 512});
      if (c > 5 || !listed) return 1'b0;
      if (f && odd) return 1'b0;
      if (f && c == 5 && r == 192) return 1'b1;
      if (r < (f ? lo1[c] : lo0[c])) return 1'b0;
      if (r > (f ? hi1[c] : hi0[c])) return 1'b0;
      return 1'b1;
   endfunction

   task automatic chk(string req, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic frames(int r, int n);
      for (int f = 0; f < n; f++)
         for (int i = 0; i < r; i++) begin
            @(negedge clk); bclk = 1'b0; fsync = (i < r / 2);
            @(negedge clk); @(negedge clk); bclk = 1'b1;
            @(negedge clk);
         end
   endtask

   task automatic close_frame();
      @(negedge clk); bclk = 1'b0; fsync = 1'b1;
      @(negedge clk); @(negedge clk); bclk = 1'b1;
      repeat (10) @(negedge clk);
   endtask

   task automatic verdict(string req, int r, int n);
      frames(r, n); close_frame();
      chk(req, clk_err, !exp_ok(r, rate_fam, rate_sel));
   endtask

   initial begin
      void'($urandom(32'h1D5A7));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 err", clk_err, 1'b0);
      chk("R12 ramp", ramp_dn, 1'b0);
      chk("R12 halt", halt, 1'b0);
      chk("R12 pwr", pwr_up, 1'b1);

      halt_dis = 1'b1;
      rate_fam = 1'b0; rate_sel = 3'd3;
      verdict("R1 125 at 48k", 125, 5);
      rate_fam = 1'b1;
      verdict("R1 125 at 44.1k", 125, 5);
      verdict("R1 non-listed 100", 100, 5);
      rate_fam = 1'b0; rate_sel = 3'd0;
      verdict("R2 16k ratio 24", 24, 5);
      verdict("R2 16k ratio 32", 32, 5);
      rate_fam = 1'b1; rate_sel = 3'd0;
      verdict("R2 14.7k ratio 32", 32, 5);
      rate_fam = 1'b1; rate_sel = 3'd5;
      verdict("R3 176.4k ratio 192", 192, 5);
      verdict("R3 176.4k ratio 256", 256, 5);
      rate_fam = 1'b0; rate_sel = 3'd4;
      verdict("R3 96k ratio 384", 384, 5);
      rate_fam = 1'b0; rate_sel = 3'd5;
      verdict("R3 192k ratio 125", 125, 5);
      rate_sel = 3'd6;
      verdict("R13 code 6", 64, 5);
      rate_sel = 3'd7;
      verdict("R13 code 7", 64, 5);
      chk("R7 no halt while disabled", halt, 1'b0);

      // hysteresis: one bad frame inside a valid stream
      rate_sel = 3'd3;
      frames(64, 4);
      err_seen = 1'b0;
      frames(100, 1); frames(64, 4); close_frame();
      chk("R4 single bad frame ignored", err_seen, 1'b0);
      frames(100, 2); frames(64, 1);
      chk("R4 two bad frames raise", clk_err, 1'b1);
      chk("R5 ramp follows error", ramp_dn, 1'b1);
      frames(64, 4); close_frame();
      chk("R5 ramp drops on recovery", ramp_dn, 1'b0);

      // exact halt timing
      halt_dis = 1'b0; halt_sel = 3'd2;
      hlen = -1;
      frames(100, 6);
      chk("R6 halt raised", halt, 1'b1);
      chk("R6 halt delay 256", hlen == HALT_BASE * 4, 1'b1);
      if (hlen != HALT_BASE * 4) $display("FAIL R6 delay actual=%0d expected=%0d", hlen, HALT_BASE * 4);
      halt_dis = 1'b1;
      frames(100, 1);
      chk("R7 disable clears halt", halt, 1'b0);
      halt_sel = 3'd0; halt_dis = 1'b0;
      frames(100, 1);
      chk("R6 halt with short select", halt, 1'b1);
      frames(64, 5); close_frame();
      chk("R8 error cleared", clk_err, 1'b0);
      chk("R8 halt cleared", halt, 1'b0);

      // watchdog
      repeat (WD_LIMIT / 2) @(negedge clk);
      chk("R9 before timeout", clk_err, 1'b0);
      repeat (WD_LIMIT / 2 + 20) @(negedge clk);
      chk("R9 after timeout", clk_err, 1'b1);
      halt_dis = 1'b1;
      frames(64, 5); close_frame();
      chk("R9 recovery", clk_err, 1'b0);

      // automatic power and rate change
      halt_dis = 1'b0; auto_pwr = 1'b1;
      @(negedge clk);
      chk("R10 locked power up", pwr_up, 1'b1);
      rate_sel = 3'd2;
      repeat (3) @(negedge clk);
      chk("R11 rate change forces error", clk_err, 1'b1);
      chk("R10 power down on error", pwr_up, 1'b0);
      frames(64, 5); close_frame();
      chk("R11 recovery after change", clk_err, 1'b0);
      halt_dis = 1'b1;
      frames(100, 3); close_frame();
      chk("R10 disabled auto follows halt", pwr_up, !halt);
      halt_dis = 1'b0;
      frames(64, 5); close_frame();
      auto_pwr = 1'b0;
      @(negedge clk);
      rate_sel = 3'd3;
      repeat (3) @(negedge clk);
      chk("R11 change without auto ignored", clk_err, 1'b0);

      // constrained random
      for (int k = 0; k < 14; k++) begin
         int ratios[16] = '{16, 24, 32, 48, 64, 96, 125, 128, 192, 250, 256, 384, 500, 512, 40, 100};
         int r = ratios[$urandom_range(15)];
         rate_fam = 1'($urandom_range(1));
         rate_sel = 3'($urandom_range(9) > 8 ? 6 : $urandom_range(5));
         halt_dis = 1'($urandom_range(1));
         auto_pwr = 1'($urandom_range(1));
         halt_sel = 3'($urandom_range(7));
         frames(r, 5); close_frame();
         chk("R1 random verdict", clk_err, !exp_ok(r, rate_fam, rate_sel));
         chk("R5 random ramp", ramp_dn, !exp_ok(r, rate_fam, rate_sel));
         if (auto_pwr && !halt_dis) chk("R10 random power", pwr_up, exp_ok(r, rate_fam, rate_sel));
         else                       chk("R10 random power", pwr_up, !halt);
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (195000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule